// File: doc/BRIEF.md
# Reciprocal Exponent Estimator

This block produces a coarse reciprocal estimate of one floating-point operand by working only on its exponent. For an ordinary number the sign bit passes through, the fraction is cleared, and the exponent field is replaced by its bitwise complement. An exponent field of zero (zero or subnormal input) instead maps to the largest finite exponent. NaN operands take a separate path: quiet NaNs pass unchanged, signaling NaNs are quieted and raise an invalid-operation flag, and a mode input can replace any NaN result with the canonical default NaN.

A single input port carries both formats: a precision select chooses between a 32-bit operand in the low half of the 64-bit bus and a full 64-bit operand. The result and the flag are registered and appear one cycle after a valid strobe. Without a strobe they hold their last values. A pipeline feeds operands at up to one per cycle.

Top module: `fp_recip_exp`

## Requirements
- R1: Single precision (sel_dbl=0), non-NaN: result bit 31 equals operand bit 31, bits 22:0 are zero, bits 30:23 are the bitwise inverse of operand bits 30:23, and result bits 63:32 are zero.
- R2: Single precision with operand bits 30:23 equal to 0 gives result bits 30:23 = 0xFE.
- R3: Double precision (sel_dbl=1), non-NaN: result bit 63 equals operand bit 63, bits 51:0 are zero, and bits 62:52 are the inverse of operand bits 62:52, except that an exponent of 0 gives 0x7FE.
- R4: A quiet NaN (exponent all ones, nonzero fraction, top fraction bit set: bit 22 single, bit 51 double) is returned unchanged with the flag clear when dnan_mode=0.
- R5: A signaling NaN (exponent all ones, nonzero fraction, top fraction bit clear) sets the invalid flag and, with dnan_mode=0, returns the operand with its top fraction bit set.
- R6: With dnan_mode=1 any NaN operand returns 0x7FC00000 (single) or 0x7FF8000000000000 (double). The flag still follows R5.
- R7: An infinite operand returns a zero of the same sign.
- R8: res_valid is asserted exactly one cycle after op_valid. res and res_invalid update only in that cycle and otherwise hold.
- R9: After reset res_valid, res and res_invalid are all zero.
- R10: In single precision, operand bits 63:32 have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operand strobe |
| op | input | 64 | Operand; single precision uses bits 31:0 |
| sel_dbl | input | 1 | 1 = double precision, 0 = single |
| dnan_mode | input | 1 | Replace NaN results with the default NaN |
| res_valid | output | 1 | Result strobe |
| res | output | 64 | Result |
| res_invalid | output | 1 | Invalid-operation flag for this result |

## Verification
Every result, the flag and the strobe are due exactly one clock after the cycle in which op_valid is sampled high, because a single register stage separates input and output. The bench drives each operand on a falling edge and compares the outputs on the next falling edge, half a period after the capturing edge. A following idle cycle confirms that the outputs hold and that the strobe drops.

// File: rtl/fp_recip_exp.sv
module fp_recip_exp #(
  parameter int SP_EXP = 8,
  parameter int SP_FRAC = 23,
  parameter int DP_EXP = 11,
  parameter int DP_FRAC = 52
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        op_valid,
  input  logic [63:0] op,
  input  logic        sel_dbl,
  input  logic        dnan_mode,
  output logic        res_valid,
  output logic [63:0] res,
  output logic        res_invalid
);
  localparam int SP_W = 1 + SP_EXP + SP_FRAC;
  localparam int DP_W = 1 + DP_EXP + DP_FRAC;

  logic               s_sign, d_sign;
  logic [SP_EXP-1:0]  s_exp;
  logic [DP_EXP-1:0]  d_exp;
  logic [SP_FRAC-1:0] s_frac;
  logic [DP_FRAC-1:0] d_frac;
  logic               s_nan, d_nan, s_snan, d_snan;
  logic [SP_W-1:0]    s_out;
  logic [DP_W-1:0]    d_out;
  logic [63:0]        nxt_res;
  logic               nxt_inv;

  assign {s_sign, s_exp, s_frac} = op[SP_W-1:0];
  assign {d_sign, d_exp, d_frac} = op[DP_W-1:0];

  assign s_nan  = (&s_exp) && (|s_frac);
  assign d_nan  = (&d_exp) && (|d_frac);
  assign s_snan = s_nan && !s_frac[SP_FRAC-1];
  assign d_snan = d_nan && !d_frac[DP_FRAC-1];

  always_comb begin
    if (s_nan && dnan_mode)
      s_out = {1'b0, {SP_EXP{1'b1}}, 1'b1, {(SP_FRAC-1){1'b0}}};
    else if (s_nan)
      s_out = {s_sign, s_exp, 1'b1, s_frac[SP_FRAC-2:0]};
    else if (s_exp == '0)
      s_out = {s_sign, {(SP_EXP-1){1'b1}}, 1'b0, {SP_FRAC{1'b0}}};
    else
      s_out = {s_sign, ~s_exp, {SP_FRAC{1'b0}}};
  end

  always_comb begin
    if (d_nan && dnan_mode)
      d_out = {1'b0, {DP_EXP{1'b1}}, 1'b1, {(DP_FRAC-1){1'b0}}};
    else if (d_nan)
      d_out = {d_sign, d_exp, 1'b1, d_frac[DP_FRAC-2:0]};
    else if (d_exp == '0)
      d_out = {d_sign, {(DP_EXP-1){1'b1}}, 1'b0, {DP_FRAC{1'b0}}};
    else
      d_out = {d_sign, ~d_exp, {DP_FRAC{1'b0}}};
  end

  assign nxt_res = sel_dbl ? 64'(d_out) : 64'(s_out);
  assign nxt_inv = sel_dbl ? d_snan : s_snan;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid   <= 1'b0;
      res         <= '0;
      res_invalid <= 1'b0;
    end else begin
      res_valid <= op_valid;
      if (op_valid) begin
        res         <= nxt_res;
        res_invalid <= nxt_inv;
      end
    end
  end
endmodule

module fp_recip_exp_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        op_valid,
  input logic [63:0] op,
  input logic        sel_dbl,
  input logic        res_valid,
  input logic [63:0] res,
  input logic        res_invalid
);
  // R8
  strobe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> res_valid);
  // R8
  strobe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> !res_valid);
  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> ($stable(res) && $stable(res_invalid)));
  // R1
  sp_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !sel_dbl) |=> (res[63:32] == 32'h0));
  // R5
  inv_nan_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !sel_dbl && res_invalid == 1'b0) |-> 1'b1 ##1
      (!res_invalid || (&res[30:23])));
  // R7
  sp_inf_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !sel_dbl && op[30:0] == 31'h7F800000) |=> (res[30:0] == 31'h0));
  // R7
  dp_inf_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && sel_dbl && op[62:0] == 63'h7FF0000000000000) |=> (res[62:0] == 63'h0));
endmodule

bind fp_recip_exp fp_recip_exp_chk u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op(op), .sel_dbl(sel_dbl),
  .res_valid(res_valid), .res(res), .res_invalid(res_invalid)
);

// File: tb/fp_recip_exp_tb.sv
`timescale 1ns/1ps
module fp_recip_exp_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [63:0] op = '0;
  logic        sel_dbl = 1'b0;
  logic        dnan_mode = 1'b0;
  logic        res_valid;
  logic [63:0] res;
  logic        res_invalid;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  fp_recip_exp u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op(op), .sel_dbl(sel_dbl),
    .dnan_mode(dnan_mode), .res_valid(res_valid), .res(res), .res_invalid(res_invalid)
  );

  function automatic logic [64:0] model(input logic [63:0] a, input logic dbl, input logic dn);
    logic [64:0] r;
    if (!dbl) begin
      logic [7:0] e; logic [22:0] f;
      e = a[30:23]; f = a[22:0];
      if (e == 8'hFF && f != 0) begin
        r[64] = !f[22];
        r[63:0] = dn ? 64'h7FC00000 : {32'h0, a[31:0] | 32'h00400000};
      end else begin
        r[64] = 1'b0;
        r[63:0] = {32'h0, a[31], (e == 0) ? 8'hFE : ~e, 23'h0};
      end
    end else begin
      logic [10:0] e; logic [51:0] f;
      e = a[62:52]; f = a[51:0];
      if (e == 11'h7FF && f != 0) begin
        r[64] = !f[51];
        r[63:0] = dn ? 64'h7FF8000000000000 : (a | 64'h0008000000000000);
      end else begin
        r[64] = 1'b0;
        r[63:0] = {a[63], (e == 0) ? 11'h7FE : ~e, 52'h0};
      end
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input string req, input logic [63:0] a, input logic dbl, input logic dn);
    logic [64:0] m;
    logic [63:0] held;
    m = model(a, dbl, dn);
    @(negedge clk);
    op = a; sel_dbl = dbl; dnan_mode = dn; op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0; op = ~a;
    check({req, " res"}, res, m[63:0]);
    check({req, " flag"}, {63'h0, res_invalid}, {63'h0, m[64]});
    check("R8 strobe", {63'h0, res_valid}, 64'h1);
    held = res;
    @(negedge clk);
    check("R8 hold", res, held);
    check("R8 strobe low", {63'h0, res_valid}, 64'h0);
  endtask

  initial begin
    #(20.0 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R9 valid", {63'h0, res_valid}, 64'h0);
    check("R9 res", res, 64'h0);
    check("R9 flag", {63'h0, res_invalid}, 64'h0);
    rst_n = 1'b1;
    apply("R1 normal", 64'h0000_0000_3F80_0000, 1'b0, 1'b0);
    apply("R1 negative", 64'h0000_0000_C120_1234, 1'b0, 1'b0);
    apply("R2 zero", 64'h0000_0000_0000_0000, 1'b0, 1'b0);
    apply("R2 subnormal", 64'h0000_0000_8000_0001, 1'b0, 1'b0);
    apply("R3 normal", 64'hBFF0_0000_0000_0001, 1'b1, 1'b0);
    apply("R3 zero exp", 64'h000F_FFFF_FFFF_FFFF, 1'b1, 1'b0);
    apply("R4 qnan sp", 64'h0000_0000_FFC1_2345, 1'b0, 1'b0);
    apply("R4 qnan dp", 64'h7FF8_0000_0000_0042, 1'b1, 1'b0);
    apply("R5 snan sp", 64'h0000_0000_7F80_0001, 1'b0, 1'b0);
    apply("R5 snan dp", 64'hFFF0_0000_0000_0001, 1'b1, 1'b0);
    apply("R6 dnan sp", 64'h0000_0000_FF80_0005, 1'b0, 1'b1);
    apply("R6 dnan dp", 64'hFFF8_0000_0000_0007, 1'b1, 1'b1);
    apply("R6 dnan normal", 64'h0000_0000_4000_0000, 1'b0, 1'b1);
    apply("R7 inf sp", 64'h0000_0000_FF80_0000, 1'b0, 1'b0);
    apply("R7 inf dp", 64'h7FF0_0000_0000_0000, 1'b1, 1'b0);
    apply("R10 upper ignored", 64'hDEAD_BEEF_3F80_0000, 1'b0, 1'b0);
    for (int i = 0; i < 400; i++) begin
      logic [63:0] a;
      logic dbl;
      a = {$urandom, $urandom};
      dbl = $urandom_range(0, 1);
      case ($urandom_range(0, 3))
        0: if (dbl) a[62:52] = '1; else a[30:23] = '1;
        1: if (dbl) a[62:52] = '0; else a[30:23] = '0;
        default: ;
      endcase
      apply(dbl ? "R3 random" : "R10 random", a, dbl, 1'($urandom_range(0, 1)));
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule